// File: doc/BRIEF.md
# MDIO Management Bus Master

This block runs register reads and writes toward Ethernet PHYs over the two-wire management bus, with a clock line (MDC) and a bidirectional data line (MDIO). A host hands over one request at a time through a valid/ready port. The request carries the direction, a flag that selects short-form (Clause 22) or extended (Clause 45) addressing, the PHY address, and a 5-bit field. That field is the register number in short form and the device number in extended form. The request also carries a 16-bit extended register number and 16-bit write data. Extended accesses go out as two frames: an address frame, then the read or write frame.

When the PHY does not drive the turnaround bit of a read low, the block clocks 32 extra input cycles to drain the PHY and reports all ones. A static per-PHY mask input switches this check off for PHYs whose turnaround is known to be faulty.

Bit timing comes from two parameters, both counted in system clock cycles. `TX_HALF` sets the MDC low time and the high time of driven bits. `RX_HIGH` sets the longer high time of received bits. Back-pressure rules: `req_ready` is high only while the block is idle, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. The response is a single-cycle `rsp_valid` pulse and cannot be stalled. `rsp_rdata` holds its value until the next read completes. The pad tristate buffer is outside the block: `mdio_oe` high means the block drives `mdio_o`.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` and `mdio_oe` are low, `req_ready` is high, `rsp_valid` is low and `rsp_rdata` is 0.
- R2: Every frame opens with 32 driven one bits, and every field goes out most significant bit first.
- R3: A short-form frame has start bits 0,1, then opcode 1,0 for a read or 0,1 for a write, then the 5-bit PHY address and the 5-bit register number.
- R4: An extended access first sends an address frame. That frame is: preamble, start 0,0, opcode 0,0, PHY address, device number, driven bits 1,0, the 16-bit register number, and one clock with MDIO released. A second frame to the same PHY and device follows, with start 0,0 and opcode 1,1 for a read or 0,1 for a write.
- R5: On a write, the header is followed by driven bits 1,0 and the 16 data bits, then one clock with MDIO released. `rsp_rdata` is left unchanged.
- R6: On a read, MDIO is released right after the header. One turnaround bit and 16 data bits are clocked in, then one more released clock. `rsp_rdata` is the 16 bits sampled, first bit as MSB.
- R7: If the sampled turnaround bit is 1 and bit [phy] of `ignore_ta_mask` is 0, the read clocks 32 further input cycles instead of the data bits, then one released clock, and returns 16'hFFFF.
- R8: If bit [phy] of `ignore_ta_mask` is 1, a turnaround bit of 1 is ignored and the read completes as in R6.
- R9: The value of a driven bit is set up at least `TX_HALF` cycles before MDC rises. MDC then stays high for exactly `TX_HALF` cycles on a driven bit and exactly `RX_HIGH` cycles on a received bit. Input bits are sampled after MDC has fallen.
- R10: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low until the access completes, and requests offered meanwhile are ignored.
- R11: `rsp_valid` pulses high for exactly one cycle when an access completes.
- R12: Whenever the block is idle, `mdio_oe` and `mdc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_c45 | input | 1 | 1 = extended (two-frame) access |
| req_phy | input | 5 | PHY address |
| req_dev_reg | input | 5 | Register number (short form) or device number (extended) |
| req_reg16 | input | 16 | Extended register number |
| req_wdata | input | 16 | Write data |
| ignore_ta_mask | input | 32 | Per-PHY turnaround check bypass |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, held between reads |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A bench-side PHY model records every MDC rising edge and feeds reply bits, so each frame is compared bit by bit with one built from the requirements. Short-form writes and reads against the maximum and minimum addresses tell opcodes and field order apart. Reads with a bad turnaround, with the mask bit both set and clear, show the flush path apart from the bypass. Extended reads and writes confirm that the address frame comes first and carries the right opcode. A write issued after a flushed read shows that the held read data survives. A request offered mid-access must leave the recorded frame untouched, and measured MDC high times separate driven bits from received bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 14;
  localparam int WTX_BITS   = 18;
  localparam int DATA_BITS  = 16;
  localparam int FLUSH_BITS = 32;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_HDR, PH_WTX, PH_RTA, PH_RDATA, PH_FLUSH, PH_REL
  } phase_e;

  // start pair, opcode, phy, 5-bit register/device
  function automatic logic [HDR_BITS-1:0] mk_hdr(logic c45, logic [1:0] op,
                                                 logic [4:0] phy, logic [4:0] r5);
    return {1'b0, ~c45, op, phy, r5};
  endfunction
endpackage

// File: rtl/mdio_bit_engine.sv
module mdio_bit_engine #(
  parameter int TX_HALF = 3,
  parameter int RX_HIGH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_rx,
  input  logic go_val,
  output logic ready,
  output logic fin,
  output logic sample,
  output logic mdc,
  output logic mdio_o,
  output logic mdio_oe,
  input  logic mdio_i
);
  localparam int MAXH = (TX_HALF > RX_HIGH) ? TX_HALF : RX_HIGH;
  localparam int CW   = $clog2(MAXH + 1);

  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH, E_SAMP} est_e;
  est_e          st;
  logic [CW-1:0] cnt;
  logic          rx_q;

  assign ready = (st == E_IDLE) && !fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      cnt     <= '0;
      rx_q    <= 1'b0;
      fin     <= 1'b0;
      sample  <= 1'b0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        E_IDLE: if (go) begin
          rx_q    <= go_rx;
          mdio_oe <= ~go_rx;
          if (!go_rx) mdio_o <= go_val;
          cnt     <= '0;
          st      <= E_LOW;
        end
        E_LOW: begin
          if (cnt == CW'(TX_HALF - 1)) begin
            cnt <= '0;
            mdc <= 1'b1;
            st  <= E_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        E_HIGH: begin
          if (cnt == (rx_q ? CW'(RX_HIGH - 1) : CW'(TX_HALF - 1))) begin
            cnt <= '0;
            mdc <= 1'b0;
            st  <= E_SAMP;
          end else cnt <= cnt + 1'b1;
        end
        E_SAMP: begin
          sample <= mdio_i;
          fin    <= 1'b1;
          st     <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_c45,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_dev_reg,
  input  logic [15:0] req_reg16,
  input  logic [15:0] req_wdata,
  input  logic [31:0] ignore_ta_mask,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  input  logic        eng_ready,
  input  logic        fin,
  input  logic        sample,
  output logic        go,
  output logic        go_rx,
  output logic        go_val
);
  phase_e      phase;
  logic [5:0]  cnt;
  logic [17:0] sr;
  logic [15:0] rx_sr;
  logic        is_write, is_c45, addr_frame, bad_ta;
  logic [4:0]  phy, dev_reg;
  logic [15:0] reg16, wdata;
  logic [1:0]  op_cur;

  assign req_ready = (phase == PH_IDLE);
  assign go        = (phase != PH_IDLE) && eng_ready;
  assign go_rx     = (phase == PH_RTA) || (phase == PH_RDATA) ||
                     (phase == PH_FLUSH) || (phase == PH_REL);
  assign go_val    = (phase == PH_PRE) ? 1'b1 : sr[17];

  always_comb begin
    if (addr_frame)  op_cur = 2'b00;
    else if (is_write) op_cur = 2'b01;
    else if (is_c45) op_cur = 2'b11;
    else             op_cur = 2'b10;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      sr         <= '0;
      rx_sr      <= '0;
      is_write   <= 1'b0;
      is_c45     <= 1'b0;
      addr_frame <= 1'b0;
      bad_ta     <= 1'b0;
      phy        <= '0;
      dev_reg    <= '0;
      reg16      <= '0;
      wdata      <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (phase == PH_IDLE) begin
        if (req_valid) begin
          is_write   <= req_write;
          is_c45     <= req_c45;
          addr_frame <= req_c45;
          phy        <= req_phy;
          dev_reg    <= req_dev_reg;
          reg16      <= req_reg16;
          wdata      <= req_wdata;
          bad_ta     <= 1'b0;
          cnt        <= '0;
          phase      <= PH_PRE;
        end
      end else if (fin) begin
        unique case (phase)
          PH_PRE: begin
            if (cnt == 6'(PRE_BITS - 1)) begin
              cnt   <= '0;
              sr    <= {mk_hdr(is_c45, op_cur, phy, dev_reg), 4'b0};
              phase <= PH_HDR;
            end else cnt <= cnt + 1'b1;
          end
          PH_HDR: begin
            sr <= sr << 1;
            if (cnt == 6'(HDR_BITS - 1)) begin
              cnt <= '0;
              if (addr_frame || is_write) begin
                sr    <= {2'b10, addr_frame ? reg16 : wdata};
                phase <= PH_WTX;
              end else phase <= PH_RTA;
            end else cnt <= cnt + 1'b1;
          end
          PH_WTX: begin
            sr <= sr << 1;
            if (cnt == 6'(WTX_BITS - 1)) begin
              cnt   <= '0;
              phase <= PH_REL;
            end else cnt <= cnt + 1'b1;
          end
          PH_RTA: begin
            cnt <= '0;
            if (!sample || ignore_ta_mask[phy]) phase <= PH_RDATA;
            else begin
              bad_ta <= 1'b1;
              phase  <= PH_FLUSH;
            end
          end
          PH_RDATA: begin
            rx_sr <= {rx_sr[14:0], sample};
            if (cnt == 6'(DATA_BITS - 1)) begin
              cnt   <= '0;
              phase <= PH_REL;
            end else cnt <= cnt + 1'b1;
          end
          PH_FLUSH: begin
            if (cnt == 6'(FLUSH_BITS - 1)) begin
              cnt   <= '0;
              phase <= PH_REL;
            end else cnt <= cnt + 1'b1;
          end
          PH_REL: begin
            cnt <= '0;
            if (addr_frame) begin
              addr_frame <= 1'b0;
              phase      <= PH_PRE;
            end else begin
              phase     <= PH_IDLE;
              rsp_valid <= 1'b1;
              if (!is_write) rsp_rdata <= bad_ta ? 16'hFFFF : rx_sr;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int TX_HALF = 3,
  parameter int RX_HIGH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_c45,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_dev_reg,
  input  logic [15:0] req_reg16,
  input  logic [15:0] req_wdata,
  input  logic [31:0] ignore_ta_mask,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic eng_ready, fin, sample, go, go_rx, go_val;

  mdio_frame_seq u_seq (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_c45, .req_phy,
    .req_dev_reg, .req_reg16, .req_wdata, .ignore_ta_mask, .rsp_valid,
    .rsp_rdata, .eng_ready, .fin, .sample, .go, .go_rx, .go_val
  );

  mdio_bit_engine #(.TX_HALF(TX_HALF), .RX_HIGH(RX_HIGH)) u_eng (
    .clk, .rst_n, .go, .go_rx, .go_val, .ready(eng_ready), .fin, .sample,
    .mdc, .mdio_o, .mdio_oe, .mdio_i
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int TX_HALF = 3,
  parameter int RX_HIGH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [15:0] rsp_rdata,
  input logic        mdc,
  input logic        mdio_oe
);
  localparam int MAXH = (TX_HALF > RX_HIGH) ? TX_HALF : RX_HIGH;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= '0;
    else if (mdc) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mdc && !mdio_oe)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata)); // R5
  AST_MDC_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> (hi_cnt < 16'(MAXH))); // R9
  AST_MDC_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt == (mdio_oe ? 16'(TX_HALF) : 16'(RX_HIGH)))); // R9
endmodule

bind mdio_master mdio_master_chk #(.TX_HALF(TX_HALF), .RX_HIGH(RX_HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int TXH = 2;
  localparam int RXH = 3;
  localparam int NV = 8;
  localparam int CAPN = 192;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_c45 = 0;
  logic [4:0] req_phy = 0, req_dev_reg = 0;
  logic [15:0] req_reg16 = 0, req_wdata = 0;
  logic [31:0] ignore_ta_mask = 0;
  logic req_ready, rsp_valid, mdc, mdio_o, mdio_oe;
  logic [15:0] rsp_rdata;
  logic mdio_i = 1;

  int checks = 0, errors = 0;
  int idx = 0, exp_len = 0;
  logic cap_oe [CAPN], cap_v [CAPN], exp_oe [CAPN], exp_v [CAPN], resp [CAPN];
  logic [15:0] prev_rdata = 0;
  int tx_hmin = 999, tx_hmax = 0, rx_hmin = 999, rx_hmax = 0, lo_min = 999;
  int hcnt = 0, lcnt = 0;
  logic oe_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.TX_HALF(TXH), .RX_HIGH(RXH)) i_mdio_master (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_c45, .req_phy,
    .req_dev_reg, .req_reg16, .req_wdata, .ignore_ta_mask, .rsp_valid,
    .rsp_rdata, .mdc, .mdio_o, .mdio_oe, .mdio_i
  );

  // PHY model: record each rising edge, present reply bit for that slot
  always @(posedge mdc) begin
    if (idx < CAPN) begin
      cap_oe[idx] = mdio_oe;
      cap_v[idx]  = mdio_o;
      mdio_i      = resp[idx];
    end
    idx = idx + 1;
  end

  // MDC timing monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (mdc) begin
      if (lcnt != 0 && lcnt < lo_min) lo_min = lcnt;
      lcnt = 0;
      hcnt = hcnt + 1;
      oe_hi = mdio_oe;
    end else begin
      if (hcnt != 0) begin
        if (oe_hi) begin
          if (hcnt < tx_hmin) tx_hmin = hcnt;
          if (hcnt > tx_hmax) tx_hmax = hcnt;
        end else begin
          if (hcnt < rx_hmin) rx_hmin = hcnt;
          if (hcnt > rx_hmax) rx_hmax = hcnt;
        end
      end
      hcnt = 0;
      if (!req_ready) lcnt = lcnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add(input int n, input logic [31:0] v, input logic oe);
    for (int i = n - 1; i >= 0; i--) begin
      exp_oe[exp_len] = oe;
      exp_v[exp_len]  = v[i];
      exp_len++;
    end
  endtask

  task automatic run(input logic wr, input logic c45, input logic ign, input logic tabad,
                     input logic [4:0] phy, input logic [4:0] dr, input logic [15:0] r16,
                     input logic [15:0] data, input logic poke);
    logic [15:0] exp_rd;
    int mism, t;
    string tag;
    for (int i = 0; i < CAPN; i++) resp[i] = 1'b1;
    exp_len = 0;
    if (c45) begin
      add(32, 32'hFFFF_FFFF, 1); add(2, 0, 1); add(2, 0, 1);
      add(5, phy, 1); add(5, dr, 1); add(2, 2, 1); add(16, r16, 1); add(1, 0, 0);
    end
    add(32, 32'hFFFF_FFFF, 1);
    add(2, c45 ? 0 : 1, 1);
    add(2, wr ? 1 : (c45 ? 3 : 2), 1);
    add(5, phy, 1); add(5, dr, 1);
    if (wr) begin
      add(2, 2, 1); add(16, data, 1);
    end else begin
      resp[exp_len] = tabad; add(1, 0, 0);
      if (tabad && !ign) add(32, 0, 0);
      else begin
        for (int i = 0; i < 16; i++) resp[exp_len + i] = data[15-i];
        add(16, 0, 0);
      end
    end
    add(1, 0, 0);
    exp_rd = wr ? prev_rdata : ((tabad && !ign) ? 16'hFFFF : data);
    ignore_ta_mask = ign ? (32'd1 << phy) : 32'd0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    idx = 0;
    req_valid = 1; req_write = wr; req_c45 = c45; req_phy = phy;
    req_dev_reg = dr; req_reg16 = r16; req_wdata = data;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      check("R10 ready low while busy", req_ready, 0);
      req_valid = 1; req_phy = ~phy; req_write = ~wr; req_dev_reg = ~dr;
      @(negedge clk);
      req_valid = 0;
    end
    t = 0;
    while (!rsp_valid && t < 5000) begin @(negedge clk); t++; end
    check("R11 completion seen", rsp_valid, 1);
    if (wr) tag = "R5 rdata kept on write";
    else if (tabad && !ign) tag = "R7 flush result";
    else if (tabad) tag = "R8 ignored turnaround";
    else tag = "R6 read data";
    check(tag, rsp_rdata, exp_rd);
    @(negedge clk);
    check("R11 single-cycle done", rsp_valid, 0);
    check("R12 idle quiet", {mdc, mdio_oe}, 0);
    mism = 0;
    for (int i = 0; i < exp_len; i++)
      if (cap_oe[i] !== exp_oe[i] || (exp_oe[i] && cap_v[i] !== exp_v[i])) mism++;
    if (c45) tag = "R2 R4 frame bits";
    else if (wr) tag = "R2 R3 R5 frame bits";
    else if (tabad && !ign) tag = "R2 R3 R7 frame bits";
    else tag = "R2 R3 R6 frame bits";
    check(tag, mism, 0);
    check({tag, " count"}, idx, exp_len);
    prev_rdata = exp_rd;
  endtask

  // {write, c45, ignore, ta_bad, phy, dev/reg, reg16, data}
  localparam logic [45:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 5'h01, 5'h00, 16'h0000, 16'hA5C3},
    {1'b0, 1'b0, 1'b0, 1'b0, 5'h1F, 5'h1F, 16'h0000, 16'h1234},
    {1'b0, 1'b0, 1'b0, 1'b1, 5'h03, 5'h02, 16'h0000, 16'h5555},
    {1'b0, 1'b0, 1'b1, 1'b1, 5'h04, 5'h05, 16'h0000, 16'h0F0F},
    {1'b1, 1'b1, 1'b0, 1'b0, 5'h0A, 5'h1E, 16'h8001, 16'h5AA5},
    {1'b0, 1'b1, 1'b0, 1'b0, 5'h15, 5'h03, 16'hFFFE, 16'h8421},
    {1'b0, 1'b1, 1'b0, 1'b1, 5'h07, 5'h01, 16'h0000, 16'h00FF},
    {1'b1, 1'b0, 1'b0, 1'b0, 5'h00, 5'h10, 16'h0000, 16'h0001}
  };

  initial begin
    repeat (CLK_PERIOD * 200000 / CLK_PERIOD) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mdc low", mdc, 0);
    check("R1 oe low", mdio_oe, 0);
    check("R1 ready high", req_ready, 1);
    check("R1 no done", rsp_valid, 0);
    check("R1 rdata zero", rsp_rdata, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R12 idle after reset", {mdc, mdio_oe}, 0);
    for (int v = 0; v < NV; v++)
      run(VEC[v][45], VEC[v][44], VEC[v][43], VEC[v][42], VEC[v][41:37],
          VEC[v][36:32], VEC[v][31:16], VEC[v][15:0], 1'b0);
    // R10: request offered mid-access is dropped
    run(1'b1, 1'b0, 1'b0, 1'b0, 5'h09, 5'h0C, 16'h0000, 16'hC0DE, 1'b1);
    run(1'b0, 1'b0, 1'b0, 1'b0, 5'h02, 5'h01, 16'h0000, 16'hBEEF, 1'b1);
    // R9 bit timing
    check("R9 tx high min", tx_hmin, TXH);
    check("R9 tx high max", tx_hmax, TXH);
    check("R9 rx high min", rx_hmin, RXH);
    check("R9 rx high max", rx_hmax, RXH);
    check("R9 low time floor", (lo_min >= TXH), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule